// File: doc/BRIEF.md
# Chase Soft-Input Soft-Output Decoder for a 16-bit Extended BCH Word

This block performs one soft-input soft-output decoding pass over a single row or column of a 16x16 product code. The row or column code is an extended BCH(16,11) code. A word arrives as sixteen consecutive symbol pairs, one pair per clock. Each pair carries the channel value R and the current soft estimate R'. The block emits sixteen refined estimates, one per clock, that feed the next half-iteration. A word travels through three pipeline stages, each of which owns its own copy of the word:

- Reception finds the two weakest positions and the hard-decision syndrome.
- Processing decodes four test patterns and keeps the best two distinct codewords.
- Emission computes the reliability, the extrinsic value and the damped update for each bit.

A new word may start as soon as the previous one has been accepted, so words can stream without gaps. The block has no iteration control and no row/column routing. Those belong to the surrounding decoder.

Top module: `chase_siso16`

## Requirements
- R1: Every soft value is 4 bits in sign-magnitude form: bit 3 is the sign (1 = negative value, hard decision 1) and bits 2:0 are the magnitude 0..7. An output of value zero is always written as 4'b0000, never 4'b1000.
- R2: A word is 16 consecutive cycles with in_valid high, holding symbols 0..15 in order. Idle cycles are allowed only between words.
- R3: Output symbol j is shown with out_valid high in the cycle that follows the 31st rising edge after the edge that captured input symbol j. Each word yields 16 consecutive valid outputs, and back-to-back words stream with no gap.
- R4: The two least reliable positions are the two smallest R' magnitudes. On equal magnitudes the lower index ranks as less reliable.
- R5: Test pattern t (0..3) inverts the weakest position when t bit 0 is set and the second weakest when t bit 1 is set. Each pattern is decoded with this code:
  - The check column of position i (0..14) is x^i mod x^4+x+1, with bit k holding the x^k coefficient. Position 15 takes part only in overall parity.
  - Zero syndrome with even parity keeps the pattern. Zero syndrome with odd parity inverts bit 15.
  - Nonzero syndrome with odd parity inverts the located bit. Nonzero syndrome with even parity makes the pattern invalid.
- R6: A candidate's metric is the sum of R' magnitudes at the positions where it differs from the hard decision. The decided word is the valid candidate with the lowest metric, with ties going to the lower pattern number. The concurrent word is the lowest-metric valid candidate that differs from the decided word, with ties going to the lower pattern number.
- R7: Reliability F for bit j carries the decided bit's sign. Its magnitude is min(7, floor((concurrent metric − decided metric)/2)) where the concurrent word differs from the decided word at j. Otherwise it is BETA (default 6), and it is also BETA when no concurrent word exists.
- R8: The output is sat7(R + ((F − R') >>> 1)), with an arithmetic shift (floor). Saturation clamps to −7..+7.
- R9: After reset out_valid is low. A word cut short by reset produces no output, and the next full word decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input symbol pair present |
| in_ch | input | 4 | Channel soft value R, sign-magnitude |
| in_cur | input | 4 | Current soft estimate R', sign-magnitude |
| out_valid | output | 1 | Output symbol present |
| out_sym | output | 4 | Updated soft estimate, sign-magnitude |

## Verification
The hardest situation to reach is the one where two test patterns decode to the same codeword. When that happens, the concurrent word must come from a later pattern, or the metric of the best pattern ties that of another pattern. Whether this occurs depends on the syndrome structure, not on any single input. The stimulus reaches it with hundreds of streamed words whose magnitudes are drawn from a narrow range. It adds words with all magnitudes equal and words with all magnitudes zero, so ties and duplicate codewords come up often. Every output symbol is compared with an arithmetic model that decodes each pattern by searching for the position whose column matches the syndrome.

// File: rtl/chase_pkg.sv
`timescale 1ns/1ps
package chase_pkg;
    localparam int N   = 16;
    localparam int Q   = 4;
    localparam int MW  = Q - 1;
    localparam int CW  = $clog2(N);
    localparam int NT  = 4;
    localparam int MET = 5;
    localparam int VW  = 6;

    typedef logic [Q-1:0] sym_t;

    typedef struct packed {
        logic [N-1:0][Q-1:0] ch;
        logic [N-1:0][Q-1:0] cur;
        logic [3:0]          syn;
        logic                par;
        logic [CW-1:0]       l1;
        logic [CW-1:0]       l2;
    } rxw_t;

    typedef struct packed {
        logic [N-1:0][Q-1:0] ch;
        logic [N-1:0][Q-1:0] cur;
        logic [N-1:0]        dmask;
        logic [N-1:0]        cmask;
        logic                cval;
        logic [MET-1:0]      dm;
        logic [MET-1:0]      cm;
    } pw_t;

    // check column of a position: x^pos mod x^4+x+1; last position has none
    function automatic logic [3:0] gf_col(input logic [CW-1:0] pos);
        logic [3:0] a;
        a = 4'b0001;
        for (int k = 0; k < N - 2; k++)
            if (k < int'(pos)) a = {a[2:0], 1'b0} ^ (a[3] ? 4'b0011 : 4'b0000);
        return (pos == CW'(N - 1)) ? 4'b0000 : a;
    endfunction

    function automatic logic [CW-1:0] gf_loc(input logic [3:0] s);
        logic [CW-1:0] r;
        r = '0;
        for (int k = 0; k < N - 1; k++)
            if (gf_col(CW'(k)) == s) r = CW'(k);
        return r;
    endfunction

    function automatic logic signed [VW-1:0] sm2int(input sym_t s);
        logic signed [VW-1:0] m;
        m = $signed({{(VW-MW){1'b0}}, s[MW-1:0]});
        return s[Q-1] ? -m : m;
    endfunction

    function automatic sym_t int2sm(input logic signed [VW-1:0] v);
        logic signed [VW-1:0] a;
        a = (v < 0) ? -v : v;
        if (a > 6'sd7) a = 6'sd7;
        return {(v < 0), a[MW-1:0]};
    endfunction
endpackage

// File: rtl/csiso_rx.sv
`timescale 1ns/1ps
module csiso_rx
    import chase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  sym_t in_ch,
    input  sym_t in_cur,
    output logic done,
    output rxw_t word
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        rxw_t          w;
        logic [MW:0]   m1;
        logic [MW:0]   m2;
    } rx_st_t;

    rx_st_t rx_q, rx_d;

    always_comb begin
        logic [MW:0] mag;
        logic        first;
        rx_d  = rx_q;
        first = (rx_q.cnt == '0);
        mag   = {1'b0, in_cur[MW-1:0]};
        if (in_valid) begin
            if (first) begin
                rx_d.w.syn = '0;
                rx_d.w.par = 1'b0;
                rx_d.m1    = (MW+1)'(1 << MW);
                rx_d.m2    = (MW+1)'(1 << MW);
            end
            rx_d.w.ch[rx_q.cnt]  = in_ch;
            rx_d.w.cur[rx_q.cnt] = in_cur;
            if (in_cur[Q-1]) begin
                rx_d.w.syn = rx_d.w.syn ^ gf_col(rx_q.cnt);
                rx_d.w.par = ~rx_d.w.par;
            end
            if (mag < rx_d.m1) begin
                rx_d.w.l2 = rx_d.w.l1;
                rx_d.m2   = rx_d.m1;
                rx_d.w.l1 = rx_q.cnt;
                rx_d.m1   = mag;
            end else if (mag < rx_d.m2) begin
                rx_d.w.l2 = rx_q.cnt;
                rx_d.m2   = mag;
            end
            rx_d.cnt = rx_q.cnt + 1'b1;
        end
        done = in_valid && (rx_q.cnt == CW'(N - 1));
        word = rx_d.w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end
endmodule

// File: rtl/csiso_proc.sv
`timescale 1ns/1ps
module csiso_proc
    import chase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  rxw_t rw,
    output logic done,
    output pw_t  pw
);
    typedef struct packed {
        logic           act;
        logic [CW-1:0]  cnt;
        rxw_t           w;
        logic           bv;
        logic           sv;
        logic [N-1:0]   bmask;
        logic [N-1:0]   smask;
        logic [MET-1:0] bm;
        logic [MET-1:0] sm;
    } pr_st_t;

    pr_st_t pr_q, pr_d;

    always_comb begin
        logic [1:0]     t;
        logic [N-1:0]   flip;
        logic [3:0]     s;
        logic           p;
        logic           ok;
        logic [MET-1:0] met;
        pr_d = pr_q;
        t    = pr_q.cnt[1:0];
        flip = (t[0] ? (N'(1) << pr_q.w.l1) : '0) ^ (t[1] ? (N'(1) << pr_q.w.l2) : '0);
        s    = pr_q.w.syn ^ (t[0] ? gf_col(pr_q.w.l1) : 4'b0) ^ (t[1] ? gf_col(pr_q.w.l2) : 4'b0);
        p    = pr_q.w.par ^ t[0] ^ t[1];
        ok   = 1'b1;
        if (s == 4'b0) begin
            if (p) flip[N-1] = ~flip[N-1];
        end else if (p) begin
            flip = flip ^ (N'(1) << gf_loc(s));
        end else begin
            ok = 1'b0;
        end
        met = '0;
        for (int i = 0; i < N; i++)
            if (flip[i]) met = met + MET'(pr_q.w.cur[i][MW-1:0]);

        if (pr_q.act) begin
            pr_d.cnt = pr_q.cnt + 1'b1;
            if (pr_q.cnt == CW'(N - 1)) pr_d.act = 1'b0;
            if ((int'(pr_q.cnt) < NT) && ok) begin
                if (!pr_q.bv || met < pr_q.bm) begin
                    pr_d.sv    = pr_q.bv;
                    pr_d.smask = pr_q.bmask;
                    pr_d.sm    = pr_q.bm;
                    pr_d.bv    = 1'b1;
                    pr_d.bmask = flip;
                    pr_d.bm    = met;
                end else if (flip != pr_q.bmask && (!pr_q.sv || met < pr_q.sm)) begin
                    pr_d.sv    = 1'b1;
                    pr_d.smask = flip;
                    pr_d.sm    = met;
                end
            end
        end
        if (load) begin
            pr_d.act = 1'b1;
            pr_d.cnt = '0;
            pr_d.w   = rw;
            pr_d.bv  = 1'b0;
            pr_d.sv  = 1'b0;
        end

        done     = pr_q.act && (pr_q.cnt == CW'(N - 1));
        pw.ch    = pr_q.w.ch;
        pw.cur   = pr_q.w.cur;
        pw.dmask = pr_q.bv ? pr_q.bmask : '0;
        pw.cmask = pr_q.smask;
        pw.cval  = pr_q.sv;
        pw.dm    = pr_q.bm;
        pw.cm    = pr_q.sm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end
endmodule

// File: rtl/csiso_emit.sv
`timescale 1ns/1ps
module csiso_emit
    import chase_pkg::*;
#(
    parameter int BETA = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  pw_t  pw,
    output logic out_valid,
    output sym_t out_sym
);
    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
        pw_t           w;
    } em_st_t;

    em_st_t em_q, em_d;

    always_comb begin
        logic                 dbit;
        logic [MET-1:0]       half;
        logic [MW-1:0]        mag;
        logic signed [VW-1:0] fval;
        logic signed [VW-1:0] wv;
        logic signed [VW-1:0] nv;
        em_d = em_q;
        if (em_q.act) begin
            em_d.cnt = em_q.cnt + 1'b1;
            if (em_q.cnt == CW'(N - 1)) em_d.act = 1'b0;
        end
        if (load) begin
            em_d.act = 1'b1;
            em_d.cnt = '0;
            em_d.w   = pw;
        end

        dbit = em_q.w.cur[em_q.cnt][Q-1] ^ em_q.w.dmask[em_q.cnt];
        half = (em_q.w.cm - em_q.w.dm) >> 1;
        if (em_q.w.cval && (em_q.w.cmask[em_q.cnt] != em_q.w.dmask[em_q.cnt]))
            mag = (half > MET'(7)) ? MW'(7) : half[MW-1:0];
        else
            mag = MW'(BETA);
        fval      = $signed({{(VW-MW){1'b0}}, mag});
        if (dbit) fval = -fval;
        wv        = fval - sm2int(em_q.w.cur[em_q.cnt]);
        nv        = sm2int(em_q.w.ch[em_q.cnt]) + (wv >>> 1);
        out_sym   = int2sm(nv);
        out_valid = em_q.act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) em_q <= '0;
        else        em_q <= em_d;
    end
endmodule

// File: rtl/chase_siso16.sv
`timescale 1ns/1ps
module chase_siso16
    import chase_pkg::*;
#(
    parameter int BETA = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [3:0] in_ch,
    input  logic [3:0] in_cur,
    output logic       out_valid,
    output logic [3:0] out_sym
);
    logic rdone;
    logic pdone;
    rxw_t rw;
    pw_t  pw;

    csiso_rx u_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_ch(in_ch), .in_cur(in_cur), .done(rdone), .word(rw)
    );

    csiso_proc u_proc (
        .clk(clk), .rst_n(rst_n), .load(rdone), .rw(rw), .done(pdone), .pw(pw)
    );

    csiso_emit #(.BETA(BETA)) u_emit (
        .clk(clk), .rst_n(rst_n), .load(pdone), .pw(pw),
        .out_valid(out_valid), .out_sym(out_sym)
    );
endmodule

// File: rtl/chase_siso16_chk.sv
`timescale 1ns/1ps
module chase_siso16_chk
    import chase_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic [3:0] out_sym,
    input logic       pdone,
    input pw_t        pw
);
    logic [CW-1:0] icnt;

    always_ff @(posedge clk) begin
        if (!rst_n)        icnt <= '0;
        else if (in_valid) icnt <= icnt + 1'b1;
    end

    // R2: once a word has started, in_valid stays high until its 16th symbol
    p_word_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (icnt != '0) |-> in_valid);

    // R3: every valid output traces back to a captured input 32 edges earlier
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 32));

    // R1: zero never leaves with the sign bit set
    p_no_negzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sym != 4'b1000));

    // R5: a decided candidate differs from the hard decision in at most three places
    p_flip_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pdone |-> ($countones(pw.dmask) <= 3));

    // R6: concurrent metric never below decided metric
    p_metric_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pdone && pw.cval) |-> (pw.cm >= pw.dm));

    // R6: concurrent word is a different codeword
    p_conc_distinct_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pdone && pw.cval) |-> (pw.cmask != pw.dmask));
endmodule

bind chase_siso16 chase_siso16_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_sym(out_sym), .pdone(pdone), .pw(pw)
);

// File: tb/sim_chase_siso16.sv
`timescale 1ns/1ps
module sim_chase_siso16;
    localparam int BETA = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [3:0] in_ch;
    logic [3:0] in_cur;
    logic       out_valid;
    logic [3:0] out_sym;

    int nchk = 0;
    int nfail = 0;
    int ecnt = 0;
    bit finished = 0;

    logic [3:0] exp_q[$];
    int         edge_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) ecnt <= ecnt + 1;

    chase_siso16 #(.BETA(BETA)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
        .in_cur(in_cur), .out_valid(out_valid), .out_sym(out_sym)
    );

    function automatic int sval(input logic [3:0] s);
        return s[3] ? -int'(s[2:0]) : int'(s[2:0]);
    endfunction

    function automatic logic [3:0] enc(input int v);
        int a;
        a = (v < 0) ? -v : v;
        if (a > 7) a = 7;
        return {(v < 0), 3'(a)};
    endfunction

    function automatic logic [3:0] colv(input int i);
        logic [3:0] a;
        a = 4'b0001;
        for (int k = 0; k < i; k++) a = {a[2:0], 1'b0} ^ (a[3] ? 4'b0011 : 4'b0000);
        return a;
    endfunction

    function automatic void model(input logic [15:0][3:0] ch, input logic [15:0][3:0] cur,
                                  output logic [15:0][3:0] o);
        int l1, l2, d, c;
        bit [15:0] h;
        bit [15:0] msk [4];
        int met [4];
        bit ok [4];
        l1 = 0;
        for (int i = 0; i < 16; i++) begin
            h[i] = cur[i][3];
            if (cur[i][2:0] < cur[l1][2:0]) l1 = i;
        end
        l2 = (l1 == 0) ? 1 : 0;
        for (int i = 0; i < 16; i++)
            if (i != l1 && cur[i][2:0] < cur[l2][2:0]) l2 = i;
        for (int t = 0; t < 4; t++) begin
            bit [15:0] y;
            logic [3:0] s;
            bit p;
            y = h;
            if (t[0]) y[l1] = ~y[l1];
            if (t[1]) y[l2] = ~y[l2];
            s = 4'b0;
            for (int i = 0; i < 15; i++) if (y[i]) s = s ^ colv(i);
            p = ^y;
            ok[t] = 1;
            if (s == 4'b0) begin
                if (p) y[15] = ~y[15];
            end else if (p) begin
                for (int i = 0; i < 15; i++) if (colv(i) == s) y[i] = ~y[i];
            end else ok[t] = 0;
            msk[t] = y ^ h;
            met[t] = 0;
            for (int i = 0; i < 16; i++) if (msk[t][i]) met[t] += int'(cur[i][2:0]);
        end
        d = -1;
        for (int t = 0; t < 4; t++) if (ok[t] && (d < 0 || met[t] < met[d])) d = t;
        c = -1;
        for (int t = 0; t < 4; t++)
            if (ok[t] && msk[t] != msk[d] && (c < 0 || met[t] < met[c])) c = t;
        for (int j = 0; j < 16; j++) begin
            int mag, f, w;
            if (c >= 0 && msk[c][j] != msk[d][j]) begin
                mag = (met[c] - met[d]) / 2;
                if (mag > 7) mag = 7;
            end else mag = BETA;
            f = (h[j] ^ msk[d][j]) ? -mag : mag;
            w = f - sval(cur[j]);
            o[j] = enc(sval(ch[j]) + (w >>> 1));
        end
    endfunction

    task automatic send(input logic [15:0][3:0] ch, input logic [15:0][3:0] cur, input string tag);
        logic [15:0][3:0] o;
        model(ch, cur, o);
        for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_ch    = ch[j];
            in_cur   = cur[j];
            exp_q.push_back(o[j]);
            edge_q.push_back(ecnt + 32);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (edge_q.size() > 0 && edge_q[0] == ecnt) begin
                nchk++;
                if (!(out_valid === 1'b1 && out_sym === exp_q[0])) begin
                    nfail++;
                    $display("FAIL %s: edge %0d valid %b sym %h, expected valid 1 sym %h",
                             tag_q[0], ecnt, out_valid, out_sym, exp_q[0]);
                end
                void'(exp_q.pop_front());
                void'(edge_q.pop_front());
                void'(tag_q.pop_front());
            end else if (out_valid === 1'b1) begin
                nchk++;
                nfail++;
                $display("FAIL R3: unexpected output at edge %0d sym %h, expected valid 0", ecnt, out_sym);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0][3:0] ch, cur;
        rst_n = 1'b0; in_valid = 1'b0; in_ch = '0; in_cur = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        nchk++;
        if (out_valid !== 1'b0) begin
            nfail++;
            $display("FAIL R9: out_valid after reset got %b expected 0", out_valid);
        end

        // R7: strong all-zero codeword
        for (int i = 0; i < 16; i++) begin ch[i] = 4'b0101; cur[i] = 4'b0111; end
        send(ch, cur, "R7");
        idle(40);

        // R5: one weak wrong bit plus a second weak position
        for (int i = 0; i < 16; i++) begin ch[i] = 4'b0011; cur[i] = 4'b0110; end
        cur[9] = 4'b1001; cur[3] = 4'b0010; ch[9] = 4'b1001;
        send(ch, cur, "R5");
        idle(40);

        // R4: equal magnitudes everywhere, some negative
        for (int i = 0; i < 16; i++) begin ch[i] = 4'(i); cur[i] = 4'b0011; end
        cur[2] = 4'b1011; cur[5] = 4'b1011;
        send(ch, cur, "R4");
        idle(40);

        // R1: all magnitudes zero, signed zeros present
        for (int i = 0; i < 16; i++) begin
            ch[i] = i[0] ? 4'b1000 : 4'b0000; cur[i] = i[1] ? 4'b1000 : 4'b0000;
        end
        send(ch, cur, "R1");
        idle(40);

        // R8: saturation in both directions
        for (int i = 0; i < 16; i++) begin
            ch[i] = i[0] ? 4'b1111 : 4'b0111; cur[i] = i[0] ? 4'b0111 : 4'b1111;
        end
        send(ch, cur, "R8");
        for (int i = 0; i < 16; i++) begin ch[i] = 4'b1111; cur[i] = 4'b0111; end
        send(ch, cur, "R8");
        idle(40);

        // R9: a word cut short by reset leaves nothing behind
        for (int j = 0; j < 7; j++) begin
            @(negedge clk);
            in_valid = 1'b1; in_ch = 4'b0111; in_cur = 4'b1001;
        end
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin ch[i] = 4'(3 * i); cur[i] = 4'(5 * i + 1); end
        send(ch, cur, "R9");
        idle(40);

        // R2: words separated by idle gaps of different lengths
        for (int w = 0; w < 6; w++) begin
            for (int i = 0; i < 16; i++) begin
                ch[i] = 4'($urandom_range(0, 15)); cur[i] = 4'($urandom_range(0, 15));
            end
            send(ch, cur, "R2");
            idle(w + 1);
        end
        idle(40);

        // R3: back-to-back streaming
        for (int w = 0; w < 8; w++) begin
            for (int i = 0; i < 16; i++) begin
                ch[i] = 4'($urandom_range(0, 15)); cur[i] = 4'($urandom_range(0, 15));
            end
            send(ch, cur, "R3");
        end
        idle(40);

        // R6: narrow magnitude range so ties and duplicate codewords are common
        for (int w = 0; w < 200; w++) begin
            for (int i = 0; i < 16; i++) begin
                ch[i]  = 4'($urandom_range(0, 15));
                cur[i] = {1'($urandom_range(0, 1)), 3'($urandom_range(0, (w % 3) + 1))};
            end
            send(ch, cur, "R6");
        end
        idle(40);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule